// File: doc/BRIEF.md
# Clock Throttle Duty Gate

This block produces a run/stop enable for a downstream clock gate. The processor runs only in some slots of each throttle period. A period has eight equal slots. A slot counter moves forward by one on each single-cycle period tick, so the slot length, and with it the period length, is set by whatever drives the tick.

A 3-bit duty code chooses how many slots at the start of the period keep the enable high. The step is one eighth, or 12.5%, per code value. The enable bit turns throttling on. When throttling is off, or the code is the reserved value zero, the output stays high. The block samples new code and enable values only at a period boundary, so a period never runs with a mix of old and new settings and the enable cannot glitch in the middle of a period.

Top module: `throttle_duty_gate`

## Requirements
- R1: While the captured enable bit is 0, `runEnable` is 1 in every slot, whatever the duty code is.
- R2: While the captured enable bit is 1 and the captured code N is between 1 and 7, slots are numbered 0 to 7 from the start of the period. `runEnable` is 1 in slots 0 to N-1 and 0 in slots N to 7, so it is high for N eighths of the period.
- R3: Code 0 with the enable bit at 1 is reserved and is treated as full duty: `runEnable` is 1 in every slot.
- R4: After reset the slot is 0, the captured enable and code are both 0, and `runEnable` is 1.
- R5: `throttleEn` and `dutyCode` are captured only on the tick that ends slot 7. The captured values apply from slot 0 of the next period. A change earlier in a period does not change the output for the rest of that period.
- R6: The slot moves forward by exactly one, from 7 back to 0, on a clock edge where `periodTick` is 1. With no tick, the slot holds for any number of cycles, and `runEnable` holds with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| throttleEn | input | 1 | Throttling enable, sampled at the period boundary |
| dutyCode | input | 3 | Run slots per period (1 to 7); 0 is reserved |
| periodTick | input | 1 | Single-cycle pulse that advances the slot |
| runEnable | output | 1 | 1 = let the clock run, 0 = stop it |

## Verification
Every duty code from 1 to 7 is driven with throttling enabled, and the high slots are compared one by one with the expected mask. This separates an off-by-one threshold from a wrong comparison direction. Code 0 with the enable set, and a nonzero code with the enable cleared, must both give a solid high output, which shows that the reserved-code path and the disable path are separate. A code change in the middle of a period checks that the remaining slots keep the old pattern. Long gaps between ticks, and tick spacing that varies, check that only the tick moves the slot.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
  typedef struct packed {
    logic slotAdvance;
    logic periodStart;
  } slot_strobe_t;
endpackage

// File: rtl/throttle_slot_ctrl.sv
module throttle_slot_ctrl
  import throttle_pkg::*;
#(
  parameter int SLOT_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 periodTick,
  output logic [SLOT_BITS-1:0] slotIdx,
  output slot_strobe_t         strobes
);
  localparam logic [SLOT_BITS-1:0] LAST_SLOT = {SLOT_BITS{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotIdx <= '0;
    else if (periodTick) slotIdx <= slotIdx + 1'b1;
  end

  always_comb begin
    strobes.slotAdvance = periodTick;
    strobes.periodStart = periodTick && (slotIdx == LAST_SLOT);
  end

  // R6: no tick, no slot movement
  a_r6_slot_hold: assert property (@(posedge clk) disable iff (!rstN)
    !periodTick |=> $stable(slotIdx));
  // R6: a tick moves the slot forward by exactly one
  a_r6_slot_step: assert property (@(posedge clk) disable iff (!rstN)
    periodTick |=> slotIdx == SLOT_BITS'($past(slotIdx) + 1'b1));
endmodule

// File: rtl/throttle_duty_path.sv
module throttle_duty_path
  import throttle_pkg::*;
#(
  parameter int SLOT_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 throttleEn,
  input  logic [SLOT_BITS-1:0] dutyCode,
  input  logic [SLOT_BITS-1:0] slotIdx,
  input  slot_strobe_t         strobes,
  output logic                 runEnable
);
  localparam logic [SLOT_BITS-1:0] RESERVED_CODE = '0;

  logic                 activeEn;
  logic [SLOT_BITS-1:0] activeCode;
  logic                 fullDuty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeEn   <= 1'b0;
      activeCode <= '0;
    end else if (strobes.periodStart) begin
      activeEn   <= throttleEn;
      activeCode <= dutyCode;
    end
  end

  always_comb begin
    fullDuty  = !activeEn || (activeCode == RESERVED_CODE);
    runEnable = fullDuty || (slotIdx < activeCode);
  end

  // R5: captured settings change only at a period boundary
  a_r5_settings_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.periodStart |=> $stable(activeEn) && $stable(activeCode));
  // R2: the first slot of every period always runs
  a_r2_first_slot_runs: assert property (@(posedge clk) disable iff (!rstN)
    (slotIdx == '0) |-> runEnable);
  // R1: throttling off holds the enable high
  a_r1_disabled_full: assert property (@(posedge clk) disable iff (!rstN)
    !activeEn |-> runEnable);
  // R6: without a tick or a boundary, the output holds
  a_r6_output_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.slotAdvance |=> $stable(runEnable));
endmodule

// File: rtl/throttle_duty_gate.sv
module throttle_duty_gate
  import throttle_pkg::*;
#(
  parameter int SLOT_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 throttleEn,
  input  logic [SLOT_BITS-1:0] dutyCode,
  input  logic                 periodTick,
  output logic                 runEnable
);
  logic [SLOT_BITS-1:0] slotIdx;
  slot_strobe_t         strobes;

  throttle_slot_ctrl #(.SLOT_BITS(SLOT_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .periodTick(periodTick),
    .slotIdx(slotIdx), .strobes(strobes)
  );

  throttle_duty_path #(.SLOT_BITS(SLOT_BITS)) path_i (
    .clk(clk), .rstN(rstN), .throttleEn(throttleEn), .dutyCode(dutyCode),
    .slotIdx(slotIdx), .strobes(strobes), .runEnable(runEnable)
  );

  // R4: the first cycle after reset runs at full duty
  a_r4_reset_runs: assert property (@(posedge clk)
    !rstN |=> runEnable);
endmodule

// File: tb/throttle_duty_gate_tb_top.sv
module throttle_duty_gate_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       throttleEn = 1'b0;
  logic [2:0] dutyCode = 3'd0;
  logic       periodTick = 1'b0;
  logic       runEnable;

  int checks = 0;
  int errors = 0;
  int benchSlot = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  throttle_duty_gate dut_i (
    .clk(clk), .rstN(rstN), .throttleEn(throttleEn), .dutyCode(dutyCode),
    .periodTick(periodTick), .runEnable(runEnable)
  );

  function automatic logic expRun(input logic en, input int code, input int slot);
    if (!en || code == 0) return 1'b1;
    return (slot < code);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: runEnable=%0b expected=%0b (slot %0d)", tag, act, exp, benchSlot);
    end
  endtask

  // one tick pulse; the sample is taken at the following negedge
  task automatic tickOnce();
    periodTick = 1'b1;
    @(negedge clk);
    periodTick = 1'b0;
    benchSlot = (benchSlot + 1) % 8;
    @(negedge clk);
  endtask

  // check from the current slot to the end of the period; ends at slot 0
  task automatic checkSlots(input logic en, input int code, input string tag);
    do begin
      check(runEnable, expRun(en, code, benchSlot), tag);
      tickOnce();
    end while (benchSlot != 0);
  endtask

  // apply settings, cross a boundary, then check one full period
  task automatic checkPeriod(input logic en, input int code, input string tag);
    throttleEn = en;
    dutyCode = 3'(code);
    do tickOnce(); while (benchSlot != 0);
    checkSlots(en, code, tag);
  endtask

  task automatic testReset();
    check(runEnable, 1'b1, "R4 during reset");
    rstN = 1'b1;
    @(negedge clk);
    check(runEnable, 1'b1, "R4 after reset");
    // settings are applied now but take effect only after 8 ticks
    throttleEn = 1'b1;
    dutyCode = 3'd1;
    tickOnce();
    check(runEnable, 1'b1, "R4 slot1 still old settings");
    while (benchSlot != 0) tickOnce();
    checkSlots(1'b1, 1, "R4 first boundary capture");
  endtask

  task automatic testAllCodes();
    for (int c = 1; c < 8; c++) checkPeriod(1'b1, c, "R2 duty code");
  endtask

  task automatic testDisabled();
    checkPeriod(1'b0, 5, "R1 disabled code5");
    checkPeriod(1'b0, 1, "R1 disabled code1");
  endtask

  task automatic testReserved();
    checkPeriod(1'b1, 0, "R3 reserved code");
  endtask

  task automatic testMidChange();
    checkPeriod(1'b1, 2, "R5 setup");
    repeat (3) begin
      check(runEnable, expRun(1'b1, 2, benchSlot), "R5 before change");
      tickOnce();
    end
    dutyCode = 3'd6;
    @(negedge clk);
    checkSlots(1'b1, 2, "R5 old settings kept");
    checkSlots(1'b1, 6, "R5 new settings applied");
    throttleEn = 1'b0;
    tickOnce();
    check(runEnable, 1'b1, "R5 enable change deferred slot1");
    while (benchSlot != 7) tickOnce();
    check(runEnable, 1'b0, "R5 enable change deferred slot7");
    tickOnce();
    checkSlots(1'b0, 6, "R5 disable applied");
  endtask

  task automatic testTickGating();
    checkPeriod(1'b1, 2, "R6 setup");
    tickOnce();
    repeat (25) @(negedge clk);
    check(runEnable, 1'b1, "R6 held in slot1");
    tickOnce();
    check(runEnable, 1'b0, "R6 advanced to slot2");
    // irregular tick spacing
    for (int g = 0; benchSlot != 0; g++) begin
      repeat (g % 4) @(negedge clk);
      check(runEnable, expRun(1'b1, 2, benchSlot), "R6 irregular ticks");
      tickOnce();
    end
    check(runEnable, 1'b1, "R6 wrap to slot0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testAllCodes();
    testDisabled();
    testReserved();
    testMidChange();
    testTickGating();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule